// File: doc/BRIEF.md
# Conditional Relative Branch Unit

This unit executes the conditional relative branch instructions of an 8-bit processor with a 16-bit program counter. The instruction decoder pulses `start` once the opcode byte has been fetched. With that pulse it presents the address of the byte after the opcode on `pc_in`, a 3-bit condition select taken from the opcode, and the four status flags. The unit latches the condition and the flags at that moment. It then drives the memory read bus itself: it fetches the signed displacement, makes the dummy reads that a taken branch needs, and reports the resulting program counter together with the total instruction cycle count.

A taken branch that stays in the same 256-byte page costs one extra cycle. A taken branch that lands in a different page costs two. In that second extra cycle the address of the dummy read depends on the processor variant, which is chosen by the parameter `CMOS_VARIANT`. The older variant reads at the partially corrected address: the high byte of the incremented PC joined to the low byte of the target. The later variant re-reads the incremented PC.

Top module: `brx_branch_unit`

## Requirements
- R1: After reset, `busy`, `done` and `rd_en` are all 0.
- R2: In the first cycle after an accepted `start`, `rd_en` is 1 and `bus_addr` equals the `pc_in` value that was sampled with `start`.
- R3: `cond_sel[2:1]` picks the flag (0 = N, 1 = V, 2 = C, 3 = Z). `cond_sel[0]` gives the flag value that takes the branch (0 = branch when the flag is clear, 1 = branch when it is set). Flags and select are sampled with `start`.
- R4: A branch that is not taken makes one read only. `done` then reports `pc_out` = start PC + 1 and `cycles` = 2.
- R5: A taken branch makes a second read, at start PC + 1, in the cycle after the displacement fetch.
- R6: For a taken branch, `pc_out` = start PC + 1 + the sign-extended displacement, modulo 2^16.
- R7: A taken branch whose target has the same high byte as start PC + 1 makes exactly two reads and reports `cycles` = 3.
- R8: A taken branch whose target has a different high byte makes a third read and reports `cycles` = 4. With `CMOS_VARIANT` = 0 this read is at {high byte of start PC + 1, low byte of target}. With `CMOS_VARIANT` = 1 it is at start PC + 1.
- R9: `start` and changes on `pc_in`, `cond_sel` or the flags while `busy` is 1 have no effect on the branch in progress.
- R10: `done` is asserted 1 cycle after the last read, lasts exactly one cycle, and `pc_out` and `cycles` keep their values after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a branch (accepted only when idle) |
| cond_sel | input | 3 | Condition select: flag in [2:1], taken polarity in [0] |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| pc_in | input | 16 | Address of the displacement byte |
| rd_data | input | 8 | Memory read data, valid in the same cycle as `bus_addr` |
| rd_en | output | 1 | Memory read strobe |
| bus_addr | output | 16 | Memory read address |
| pc_out | output | 16 | Resulting program counter |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Branch in progress |
| cycles | output | 3 | Total instruction cycle count (2, 3 or 4) |

## Verification
The assertions assume that memory answers combinationally: `rd_data` must be valid in the same cycle as the `bus_addr` that requests it. They also assume that `rst` is held until the first clock edge has passed. The bench drives `rd_data` from a continuous assignment on each instance's own address and holds reset for several cycles. Inputs change only on the falling edge. Random programs counters, displacements and flag sets are mixed with directed page-edge cases, including a wrap past address FFFF. A second `start` is injected while the unit is busy, to show that it is ignored.

// File: rtl/brx_pkg.sv
package brx_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        FLG_N = 2'd0,
        FLG_V = 2'd1,
        FLG_C = 2'd2,
        FLG_Z = 2'd3
    } flag_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FETCH   = 2'd1,
        ST_DUMMY   = 2'd2,
        ST_PENALTY = 2'd3
    } br_state_e;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } flags_t;

    function automatic logic cond_true(input logic [2:0] sel, input flags_t f);
        logic picked;
        case (flag_sel_e'(sel[2:1]))
            FLG_N:   picked = f.n;
            FLG_V:   picked = f.v;
            FLG_C:   picked = f.c;
            default: picked = f.z;
        endcase
        return picked == sel[0];
    endfunction

endpackage

// File: rtl/brx_cond.sv
module brx_cond
    import brx_pkg::*;
(
    input  logic [2:0] sel,
    input  flags_t     flags,
    output logic       take
);
    always_comb take = cond_true(sel, flags);
endmodule

// File: rtl/brx_target.sv
module brx_target #(
    parameter int AW = brx_pkg::ADDR_W,
    parameter int DW = brx_pkg::DATA_W,
    parameter bit CMOS_VARIANT = 1'b0
) (
    input  logic [AW-1:0] pc_next,
    input  logic [DW-1:0] disp,
    output logic [AW-1:0] target,
    output logic          crosses,
    output logic [AW-1:0] penalty_addr
);
    localparam int EXT_W = AW - DW;

    logic [AW-1:0] disp_ext;

    always_comb begin
        disp_ext = {{EXT_W{disp[DW-1]}}, disp};
        target   = pc_next + disp_ext;
        crosses  = target[AW-1:DW] != pc_next[AW-1:DW];
    end

    generate
        if (CMOS_VARIANT) begin : g_cmos
            always_comb penalty_addr = pc_next;
        end else begin : g_nmos
            always_comb penalty_addr = {pc_next[AW-1:DW], target[DW-1:0]};
        end
    endgenerate

    // R8: the penalty read never leaves the page of the incremented PC
    always_comb begin
        a_r8_penalty_page: assert (penalty_addr[AW-1:DW] == pc_next[AW-1:DW]);
    end
endmodule

// File: rtl/brx_seq.sv
module brx_seq
    import brx_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          take_in,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] rd_data,
    input  logic [AW-1:0] target,
    input  logic          crosses,
    input  logic [AW-1:0] penalty_addr,
    output logic [AW-1:0] pc_next,
    output logic [DW-1:0] disp,
    output logic          rd_en,
    output logic [AW-1:0] bus_addr,
    output logic [AW-1:0] pc_out,
    output logic          done,
    output logic          busy,
    output logic [2:0]    cycles
);
    localparam logic [2:0] CYC_SKIP  = 3'd2;
    localparam logic [2:0] CYC_NEAR  = 3'd3;
    localparam logic [2:0] CYC_FAR   = 3'd4;

    br_state_e     state;
    logic [AW-1:0] pc_q;
    logic          take_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            pc_q    <= '0;
            take_q  <= 1'b0;
            pc_next <= '0;
            disp    <= '0;
            pc_out  <= '0;
            done    <= 1'b0;
            cycles  <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        pc_q   <= pc_in;
                        take_q <= take_in;
                        state  <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    disp    <= rd_data;
                    pc_next <= pc_q + 1'b1;
                    if (take_q) begin
                        state <= ST_DUMMY;
                    end else begin
                        pc_out <= pc_q + 1'b1;
                        cycles <= CYC_SKIP;
                        done   <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                ST_DUMMY: begin
                    if (crosses) begin
                        state <= ST_PENALTY;
                    end else begin
                        pc_out <= target;
                        cycles <= CYC_NEAR;
                        done   <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: begin
                    pc_out <= target;
                    cycles <= CYC_FAR;
                    done   <= 1'b1;
                    state  <= ST_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        busy  = state != ST_IDLE;
        rd_en = busy;
        case (state)
            ST_DUMMY:   bus_addr = pc_next;
            ST_PENALTY: bus_addr = penalty_addr;
            default:    bus_addr = pc_q;
        endcase
    end

    a_r2_fetch_after_start: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start) |=> (rd_en && bus_addr == $past(pc_in)));

    a_r5_dummy_at_next: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH && take_q) |=> (bus_addr == AW'($past(bus_addr) + 1'b1)));

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && $stable(pc_out) && $stable(cycles)));

    a_r8_cycle_range: assert property (@(posedge clk) disable iff (rst)
        done |-> (cycles >= CYC_SKIP && cycles <= CYC_FAR));

    a_r9_busy_holds_pc: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(pc_q));
endmodule

// File: rtl/brx_branch_unit.sv
module brx_branch_unit
    import brx_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter bit CMOS_VARIANT = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [2:0]    cond_sel,
    input  logic          flag_n,
    input  logic          flag_v,
    input  logic          flag_z,
    input  logic          flag_c,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] rd_data,
    output logic          rd_en,
    output logic [AW-1:0] bus_addr,
    output logic [AW-1:0] pc_out,
    output logic          done,
    output logic          busy,
    output logic [2:0]    cycles
);
    flags_t        flags;
    logic          take;
    logic [AW-1:0] pc_next;
    logic [DW-1:0] disp;
    logic [AW-1:0] target;
    logic          crosses;
    logic [AW-1:0] penalty_addr;

    always_comb flags = '{n: flag_n, v: flag_v, z: flag_z, c: flag_c};

    brx_cond u_cond (
        .sel   (cond_sel),
        .flags (flags),
        .take  (take)
    );

    brx_target #(.AW(AW), .DW(DW), .CMOS_VARIANT(CMOS_VARIANT)) u_target (
        .pc_next      (pc_next),
        .disp         (disp),
        .target       (target),
        .crosses      (crosses),
        .penalty_addr (penalty_addr)
    );

    brx_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .take_in      (take),
        .pc_in        (pc_in),
        .rd_data      (rd_data),
        .target       (target),
        .crosses      (crosses),
        .penalty_addr (penalty_addr),
        .pc_next      (pc_next),
        .disp         (disp),
        .rd_en        (rd_en),
        .bus_addr     (bus_addr),
        .pc_out       (pc_out),
        .done         (done),
        .busy         (busy),
        .cycles       (cycles)
    );

    a_r1_idle_no_read: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !rd_en);
endmodule

// File: tb/brx_branch_unit_tb.sv
`timescale 1ns/1ps
module brx_branch_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  cond_sel = '0;
    logic        flag_n = 0, flag_v = 0, flag_z = 0, flag_c = 0;
    logic [15:0] pc_in = '0;
    logic [7:0]  disp_drv = '0;
    logic [15:0] fetch_addr = '0;

    logic        rd_en_n, done_n, busy_n, rd_en_c, done_c, busy_c;
    logic [15:0] addr_n, addr_c, pco_n, pco_c;
    logic [2:0]  cyc_n, cyc_c;
    logic [7:0]  rdd_n, rdd_c;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    assign rdd_n = (addr_n == fetch_addr) ? disp_drv : 8'hA5;
    assign rdd_c = (addr_c == fetch_addr) ? disp_drv : 8'h5A;

    brx_branch_unit #(.CMOS_VARIANT(1'b0)) u_dut (
        .clk(clk), .rst(rst), .start(start), .cond_sel(cond_sel),
        .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c),
        .pc_in(pc_in), .rd_data(rdd_n), .rd_en(rd_en_n), .bus_addr(addr_n),
        .pc_out(pco_n), .done(done_n), .busy(busy_n), .cycles(cyc_n));

    brx_branch_unit #(.CMOS_VARIANT(1'b1)) u_dut_cmos (
        .clk(clk), .rst(rst), .start(start), .cond_sel(cond_sel),
        .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c),
        .pc_in(pc_in), .rd_data(rdd_c), .rd_en(rd_en_c), .bus_addr(addr_c),
        .pc_out(pco_c), .done(done_c), .busy(busy_c), .cycles(cyc_c));

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit exp_take(input logic [2:0] sel, input logic [3:0] fl);
        logic f;
        case (sel[2:1])
            2'd0: f = fl[3];
            2'd1: f = fl[2];
            2'd2: f = fl[0];
            default: f = fl[1];
        endcase
        return f == sel[0];
    endfunction

    task automatic run_one(input logic [15:0] pc, input logic [2:0] sel,
                           input logic [3:0] fl, input logic [7:0] d, input bit poke);
        logic [15:0] an [4];
        logic [15:0] ac [4];
        int cn = 0, cc = 0;
        logic [15:0] gpn = '0, gpc = '0;
        logic [2:0]  gcn = '0, gcc = '0;
        bit fin = 0;
        logic [15:0] p1, tg, pen_n;
        bit tk, cr;
        int ne;
        logic [2:0] ecyc;
        for (int i = 0; i < 4; i++) begin an[i] = '0; ac[i] = '0; end
        p1 = pc + 16'd1;
        tg = p1 + {{8{d[7]}}, d};
        tk = exp_take(sel, fl);
        cr = tk && (tg[15:8] != p1[15:8]);
        pen_n = {p1[15:8], tg[7:0]};
        ne = !tk ? 1 : (cr ? 3 : 2);
        ecyc = 3'(ne + 1);

        @(negedge clk);
        pc_in = pc; cond_sel = sel; {flag_n, flag_v, flag_z, flag_c} = fl;
        disp_drv = d; fetch_addr = pc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R9: a new start with different inputs while busy
            pc_in = ~pc; cond_sel = ~sel; {flag_n, flag_v, flag_z, flag_c} = ~fl;
            start = 1'b1;
        end
        for (int k = 0; k < 8; k++) begin
            if (rd_en_n && cn < 4) begin an[cn] = addr_n; cn++; end
            if (rd_en_c && cc < 4) begin ac[cc] = addr_c; cc++; end
            if (done_n) begin gpn = pco_n; gcn = cyc_n; fin = 1; end
            if (done_c) begin gpc = pco_c; gcc = cyc_c; end
            if (fin) break;
            @(negedge clk);
            start = 1'b0;
        end
        chk("R4/R7/R8 read count nmos", 16'(cn), 16'(ne));
        chk("R4/R7/R8 read count cmos", 16'(cc), 16'(ne));
        chk("R2 fetch addr nmos", an[0], pc);
        chk("R2 fetch addr cmos", ac[0], pc);
        if (ne > 1) begin
            chk("R5 dummy addr nmos", an[1], p1);
            chk("R5 dummy addr cmos", ac[1], p1);
        end
        if (ne > 2) begin
            chk("R8 penalty addr nmos", an[2], pen_n);
            chk("R8 penalty addr cmos", ac[2], p1);
        end
        chk("R3/R6 pc_out nmos", gpn, tk ? tg : p1);
        chk("R3/R6 pc_out cmos", gpc, tk ? tg : p1);
        chk("R7 cycles nmos", 16'(gcn), 16'(ecyc));
        chk("R7 cycles cmos", 16'(gcc), 16'(ecyc));
        @(negedge clk);
        chk("R10 done drops", 16'(done_n), 16'd0);
        chk("R10 pc_out held", pco_n, tk ? tg : p1);
        chk("R10 cycles held", 16'(cyc_n), 16'(ecyc));
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy after reset", 16'(busy_n), 16'd0);
        chk("R1 done after reset", 16'(done_n), 16'd0);
        chk("R1 rd_en after reset", 16'(rd_en_n), 16'd0);
        chk("R1 rd_en cmos after reset", 16'(rd_en_c), 16'd0);

        // R4: not taken (branch when N set, N clear)
        run_one(16'h1234, 3'b001, 4'b0000, 8'h10, 0);
        // R7: taken in page (branch when Z set)
        run_one(16'h2010, 3'b111, 4'b0010, 8'h20, 0);
        // R8: forward page cross
        run_one(16'h30F0, 3'b100, 4'b0000, 8'h40, 0);
        // R8: backward page cross, displacement 0x80
        run_one(16'h4005, 3'b010, 4'b0000, 8'h80, 0);
        // R6: wrap past FFFF
        run_one(16'hFFFE, 3'b101, 4'b0001, 8'h02, 0);
        // R6: displacement -2 loops onto the opcode itself
        run_one(16'h5001, 3'b000, 4'b0000, 8'hFE, 0);
        // R9: start pulsed while busy is ignored
        run_one(16'h60FA, 3'b011, 4'b0100, 8'h30, 1);
        run_one(16'h7000, 3'b110, 4'b0010, 8'h05, 1);
        // R3: every select with both flag values
        for (int s = 0; s < 8; s++) begin
            run_one(16'h8100, 3'(s), 4'b0000, 8'h04, 0);
            run_one(16'h8100, 3'(s), 4'b1111, 8'h04, 0);
        end
        for (int r = 0; r < 60; r++) begin
            run_one(16'($urandom), 3'($urandom), 4'($urandom), 8'($urandom), bit'($urandom));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule